// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Port

This block is an eight-line general-purpose I/O port that sits on a simple APB-style register bus with byte-wide registers. Software sets each line as an input or an output. The pad output enables and output values follow that setting. A data window uses address bits 9..2 as a per-line mask, so a single access can read or update any chosen subset of lines without a read-modify-write.

Each input is synchronised through two flops. A per-line detector then raises status on a high or low level, on a rising or falling edge, or on both edges. Edge status stays latched until software writes a one to the clear register. Level status follows the pin directly. Status is gated by an enable mask, and all gated bits are ORed into one interrupt pin.

The bus has no wait states. A write takes effect on the clock edge that ends its access cycle (`psel` and `penable` both high). `prdata` is combinational from register state while `psel` is high and `pwrite` is low, and is zero otherwise. The bus interface is plain control and status, so it has no valid/ready stream and no back-pressure.

Top module: `gpio_sense_port`

## Requirements
- R1: After reset, all control registers read zero, `gpio_oe` and `gpio_out` are zero, raw and gated status read zero, and `irq` is low.
- R2: Bit n of the direction register (address 0x400) set to 1 makes line n an output: `gpio_oe[n]` is 1 and `gpio_out[n]` shows the stored data bit. With the bit at 0, `gpio_oe[n]` and `gpio_out[n]` are 0.
- R3: A write to an address below 0x400 updates stored data bit n only when address bit n+2 is 1. All other stored bits are unchanged, including when the mask is zero.
- R4: A read below 0x400 returns, for each line whose address bit n+2 is 1, the stored data bit if the line is an output and the synchronised pin if it is an input. Lines outside the mask read 0.
- R5: Pin changes pass through exactly two register stages. A read whose access cycle begins on the first clock edge after a pin change still returns the old value. A read one cycle later returns the new value.
- R6: With the sense bit (0x404) at 1, the line is level-sensitive. The event bit (0x40C) selects high (1) or low (0). Raw status follows the synchronised pin, a clear write leaves it unchanged, and it is never held after the level goes away.
- R7: With sense 0 and both-edges bit (0x408) at 0, an event bit of 1 latches raw status on a rising edge and 0 latches it on a falling edge. The opposite edge leaves latched status set.
- R8: With sense 0 and the both-edges bit at 1, either edge latches raw status, whatever the event bit holds.
- R9: Writing to the clear register (0x41C) clears latched edge status only for lines written with 1. Lines written with 0 keep their status. An edge in the same cycle as a clear for that line leaves the status set.
- R10: Gated status (0x418) equals raw status (0x414) AND the enable register (0x410). `irq` is high exactly when any gated bit is 1.
- R11: Control registers 0x400, 0x404, 0x408, 0x40C and 0x410 read back the last written value. Raw and gated status are read-only, and the clear register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 9 | Byte address bits 10:2 |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data |
| gpio_in | input | 8 | Asynchronous pin inputs |
| gpio_out | output | 8 | Pin output values |
| gpio_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Several kinds of internal fault show up at the ports, each within a few cycles:
- A wrong synchroniser depth shifts the cycle in which a pin change first appears in a data read. The bench checks that cycle exactly.
- A detector whose edge polarity, both-edges override or clear gating is wrong shows up in the raw status read about two cycles after the provoking pin change or clear write.
- A corrupted mask in the data window shows up at once on `gpio_out` or in the next read.
- A wrong enable gate shows up in the same cycle on `irq`.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;
  // Control-space register select, taken from byte address bits 4:2.
  typedef enum logic [2:0] {
    SEL_DIR    = 3'd0,
    SEL_SENSE  = 3'd1,
    SEL_BOTH   = 3'd2,
    SEL_EVENT  = 3'd3,
    SEL_IE     = 3'd4,
    SEL_RAW    = 3'd5,
    SEL_MASKED = 3'd6,
    SEL_CLR    = 3'd7
  } ctl_sel_e;
endpackage

// File: rtl/gpio_sense_sync.sv
module gpio_sense_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_sense_det.sv
module gpio_sense_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic lvl_mode,
  input  logic any_edge,
  input  logic pol,
  input  logic clr,
  output logic raw
);
  logic prev_q, latch_q, rise, fall, hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;
  assign hit  = any_edge ? (rise | fall) : (pol ? rise : fall);

  // An edge takes priority over a clear written in the same cycle.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        latch_q <= 1'b0;
    else if (lvl_mode) latch_q <= 1'b0;
    else if (hit)      latch_q <= 1'b1;
    else if (clr)      latch_q <= 1'b0;

  assign raw = lvl_mode ? (pin_s == pol) : latch_q;

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && clr && !hit) |=> !latch_q);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && hit) |=> latch_q);
  assert_level_unlatched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_mode |=> !latch_q);
endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
  import gpio_sense_pkg::*;
#(
  parameter int NLINES      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = NLINES + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:2] paddr,
  input  logic [NLINES-1:0] pwdata,
  output logic [NLINES-1:0] prdata,
  input  logic [NLINES-1:0] gpio_in,
  output logic [NLINES-1:0] gpio_out,
  output logic [NLINES-1:0] gpio_oe,
  output logic              irq
);
  localparam int CTL_BIT = NLINES + 2;

  logic [NLINES-1:0] dir_q, sense_q, both_q, event_q, ie_q, data_q;
  logic [NLINES-1:0] pin_s, raw, masked, clr_vec, win_mask, rd_val;
  logic              wr_en, is_ctl;
  ctl_sel_e          sel;

  assign wr_en    = psel & penable & pwrite;
  assign is_ctl   = paddr[CTL_BIT];
  assign win_mask = paddr[NLINES+1:2];
  assign sel      = ctl_sel_e'(paddr[4:2]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ie_q    <= '0;
      data_q  <= '0;
    end else if (wr_en) begin
      if (!is_ctl) data_q <= (data_q & ~win_mask) | (pwdata & win_mask);
      else begin
        case (sel)
          SEL_DIR:   dir_q   <= pwdata;
          SEL_SENSE: sense_q <= pwdata;
          SEL_BOTH:  both_q  <= pwdata;
          SEL_EVENT: event_q <= pwdata;
          SEL_IE:    ie_q    <= pwdata;
          default:   ;
        endcase
      end
    end

  assign clr_vec = (wr_en && is_ctl && sel == SEL_CLR) ? pwdata : '0;

  gpio_sense_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(pin_s)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    gpio_sense_det u_det (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]),
      .lvl_mode(sense_q[i]), .any_edge(both_q[i]), .pol(event_q[i]),
      .clr(clr_vec[i]), .raw(raw[i])
    );
  end

  assign masked   = raw & ie_q;
  assign irq      = |masked;
  assign gpio_oe  = dir_q;
  assign gpio_out = data_q & dir_q;

  always_comb begin
    rd_val = '0;
    if (!is_ctl) rd_val = ((data_q & dir_q) | (pin_s & ~dir_q)) & win_mask;
    else begin
      case (sel)
        SEL_DIR:    rd_val = dir_q;
        SEL_SENSE:  rd_val = sense_q;
        SEL_BOTH:   rd_val = both_q;
        SEL_EVENT:  rd_val = event_q;
        SEL_IE:     rd_val = ie_q;
        SEL_RAW:    rd_val = raw;
        SEL_MASKED: rd_val = masked;
        default:    rd_val = '0;
      endcase
    end
    prdata = (psel && !pwrite) ? rd_val : '0;
  end

  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ctl && sel == SEL_DIR) |=> gpio_oe == $past(pwdata));
  assert_data_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_ctl) |=> ((data_q ^ $past(data_q)) & ~$past(win_mask)) == '0);
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !is_ctl) |=> $stable(data_q));
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);
endmodule

// File: tb/gpio_sense_port_bench.sv
`timescale 1ns/1ps
module gpio_sense_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [10:2] paddr = '0;
  logic [7:0] pwdata = '0;
  logic [7:0] prdata;
  logic [7:0] gpio_in = '0;
  logic [7:0] gpio_out, gpio_oe;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];
  string req_q[$];

  localparam int A_DIR = 'h400, A_SENSE = 'h404, A_BOTH = 'h408, A_EVENT = 'h40C;
  localparam int A_IE = 'h410, A_RAW = 'h414, A_MSK = 'h418, A_CLR = 'h41C;

  always #2 clk = ~clk;

  gpio_sense_port u_gpio_sense_port (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  // Monitor: compare each read as the design returns it in its access cycle.
  always @(negedge clk) begin
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      int e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (prdata !== e[7:0]) begin
        errors++;
        $display("FAIL %s read addr %h: actual %h expected %h", r, {paddr, 2'b00}, prdata, e[7:0]);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a[10:2]; pwdata = d[7:0];
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input int a, input int e, input string r);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a[10:2];
    exp_q.push_back(e); req_q.push_back(r);
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  task automatic rd_pin_change(input int a, input int newin, input int e, input string r);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a[10:2]; gpio_in = newin[7:0];
    exp_q.push_back(e); req_q.push_back(r);
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  task automatic pins(input int oe, input int out, input bit ir, input string r);
    @(negedge clk);
    checks++;
    if (gpio_oe !== oe[7:0] || gpio_out !== out[7:0] || irq !== ir) begin
      errors++;
      $display("FAIL %s pins: actual oe %h out %h irq %b expected oe %h out %h irq %b",
               r, gpio_oe, gpio_out, irq, oe[7:0], out[7:0], ir);
    end
  endtask

  task automatic set_in(input int v);
    gpio_in = v[7:0];
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    pins(0, 0, 0, "R1");
    rd(A_DIR, 0, "R1"); rd(A_SENSE, 0, "R1"); rd(A_EVENT, 0, "R1");
    rd(A_IE, 0, "R1"); rd(A_RAW, 0, "R1"); rd(A_MSK, 0, "R1");
    // R2 / R11 direction
    wr(A_DIR, 'hF0); rd(A_DIR, 'hF0, "R11");
    wr('h3FC, 'hA5); pins('hF0, 'hA0, 0, "R2");
    wr(A_DIR, 'hF1); pins('hF1, 'hA1, 0, "R2");
    wr(A_DIR, 'hF0);
    // R3 masked writes
    wr('h080, 'h00); pins('hF0, 'h80, 0, "R3");
    wr('h040, 'hFF); pins('hF0, 'h90, 0, "R3");
    wr('h000, 'hFF); pins('hF0, 'h90, 0, "R3");
    // R4 masked reads
    set_in('h0C);
    rd('h3FC, 'h9C, "R4"); rd('h030, 'h0C, "R4");
    rd('h0C0, 'h10, "R4"); rd('h004, 'h00, "R4");
    // R5 synchroniser latency
    rd_pin_change('h004, 'h0D, 'h00, "R5");
    rd('h004, 'h01, "R5");
    // R6 level sensing on line 0
    wr(A_SENSE, 'h01); wr(A_EVENT, 'h01); wr(A_IE, 'h01);
    rd(A_RAW, 'h01, "R6"); rd(A_MSK, 'h01, "R10"); pins('hF0, 'h90, 1, "R10");
    wr(A_CLR, 'h01); rd(A_RAW, 'h01, "R6");
    set_in('h0C); rd(A_RAW, 'h00, "R6"); pins('hF0, 'h90, 0, "R6");
    wr(A_EVENT, 'h00); rd(A_RAW, 'h01, "R6");
    wr(A_SENSE, 'h00); rd(A_RAW, 'h00, "R6");
    rd(A_CLR, 'h00, "R11"); rd(A_SENSE, 'h00, "R11");
    // R7 rising then falling on line 1
    wr(A_IE, 'h02); wr(A_EVENT, 'h02);
    set_in('h0E); rd(A_RAW, 'h02, "R7"); pins('hF0, 'h90, 1, "R7");
    set_in('h0C); rd(A_RAW, 'h02, "R7");
    wr(A_CLR, 'h00); rd(A_RAW, 'h02, "R9");
    wr(A_CLR, 'h02); rd(A_RAW, 'h00, "R9"); pins('hF0, 'h90, 0, "R9");
    wr(A_EVENT, 'h00);
    set_in('h0E); rd(A_RAW, 'h00, "R7");
    set_in('h0C); rd(A_RAW, 'h02, "R7");
    wr(A_CLR, 'h02);
    // R8 both edges, event bit says falling
    wr(A_BOTH, 'h02); rd(A_BOTH, 'h02, "R11");
    set_in('h0E); rd(A_RAW, 'h02, "R8");
    wr(A_CLR, 'h02); rd(A_RAW, 'h00, "R9");
    set_in('h0C); rd(A_RAW, 'h02, "R8");
    // R10 enable gating with two latched lines
    wr(A_IE, 'h00); rd(A_MSK, 'h00, "R10"); pins('hF0, 'h90, 0, "R10");
    set_in('h04); rd(A_RAW, 'h0A, "R10");
    wr(A_IE, 'h08); rd(A_MSK, 'h08, "R10"); pins('hF0, 'h90, 1, "R10");
    wr(A_IE, 'h02); rd(A_MSK, 'h02, "R10");
    wr(A_CLR, 'h0A); rd(A_RAW, 'h00, "R9"); pins('hF0, 'h90, 0, "R10");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule